// File: doc/BRIEF.md
# Virtually-Tagged Instruction Cache Directory

This block holds the tag and valid state of an instruction cache whose set is picked by untranslated low address bits, while each line is tagged with its full virtual identity: the upper effective-address bits, an 8-bit process identifier and a one-bit address-space flag. Because the tag is virtual, two or more lines that translate to the same physical memory (synonyms) can sit in the directory together, each reachable only through its own virtual tag.

Three request ports act on it. The fetch lookup port compares a virtual tag against all ways of the addressed set and returns, one cycle later, a hit flag and the hitting way. The fill port places a new tag after a miss, but only when the page is executable and cacheable; it chooses the way itself, taking the lowest invalid way or else a per-set rotating pointer. The invalidate port removes just the line whose complete virtual tag matches, with the space bit supplied by the data-side flag. A flash input empties the whole directory in one cycle. The offset, index and way counts are parameters; the default is 32-byte lines, 16 sets and 64 ways (32 KB).

Top module: `itd_directory`

## Requirements
- R1: The set index is effective-address bits [OFFSET_W+INDEX_W-1:OFFSET_W] (bits [8:5] by default, little-endian numbering), bits [OFFSET_W-1:0] are ignored, and the tag is {address bits [31:OFFSET_W+INDEX_W], process ID, space bit}; a lookup hits only when all three parts equal a valid line of the indexed set.
- R2: One cycle after lk_valid is high, lk_resp_valid is high with lk_hit and lk_way; one cycle after lk_valid is low, lk_resp_valid and lk_hit are low.
- R3: At most one way of a set matches a lookup, and lk_way gives that way's number when lk_hit is high (0 on a miss).
- R4: A fill is carried out only when fill_exec is 1 and fill_inhibit is 0; otherwise it is dropped and no line changes.
- R5: A fill writes the lowest-numbered invalid way of its set; when all ways are valid it writes the way named by that set's rotating pointer (0 after reset), which then steps by one, wrapping from WAYS-1 to 0.
- R6: A fill whose tag already matches a valid line of its set is dropped, so no tag is stored twice in a set and the pointer does not move.
- R7: An invalidate clears only a valid line of its set whose tag, built with inv_dspace as the space bit, matches fully; synonym lines with another upper address, process ID or space bit stay valid.
- R8: flash_inv clears every valid bit in one cycle; a lookup in that cycle reports a miss and a fill or invalidate in that cycle is dropped.
- R9: When a lookup and an invalidate address the same set in one cycle the lookup reports a miss; in different sets the lookup is unaffected.
- R10: When a fill and an invalidate address the same set in one cycle the fill is dropped.
- R11: A lookup sees the directory as it was before the edge, so a fill in the same cycle becomes visible to the next cycle's lookup.
- R12: Reset leaves every line invalid, every pointer at 0 and all response outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flash_inv | input | 1 | Clear all lines |
| lk_valid | input | 1 | Lookup request |
| lk_ea | input | ADDR_W | Lookup effective address |
| lk_pid | input | PID_W | Lookup process ID |
| lk_ispace | input | 1 | Lookup address-space bit (instruction side) |
| lk_resp_valid | output | 1 | Lookup response valid |
| lk_hit | output | 1 | Lookup hit |
| lk_way | output | WAY_W | Hitting way |
| fill_valid | input | 1 | Fill request |
| fill_ea | input | ADDR_W | Fill effective address |
| fill_pid | input | PID_W | Fill process ID |
| fill_ispace | input | 1 | Fill address-space bit |
| fill_exec | input | 1 | Page has execute permission |
| fill_inhibit | input | 1 | Page is caching-inhibited |
| inv_valid | input | 1 | Invalidate request |
| inv_ea | input | ADDR_W | Invalidate effective address |
| inv_pid | input | PID_W | Invalidate process ID |
| inv_dspace | input | 1 | Invalidate address-space bit (data side) |

## Verification
The assertions check on every cycle the response timing, that no more than one way matches a lookup or an invalidate, that a refused fill leaves every valid bit untouched, that flash empties the directory, and that a same-set invalidate or a flash forces a lookup miss. Which way a fill lands in, the rotation of the pointer, the survival of synonym lines after an invalidate, the dropping of duplicate and conflicting fills, and the ordering of a fill against a same-cycle lookup only show through the bench's scenarios, which compare every response with a model of the tag array kept in the bench.

// File: rtl/itd_pkg.sv
package itd_pkg;
   // Width of a process identifier carried in every tag.
   localparam int unsigned PID_W = 8;

   // Bits of an address that translation never changes.
   localparam int unsigned UNXLATE_W = 10;

   // Index width for a count, never below one bit.
   function automatic int unsigned idx_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/itd_match.sv
// Compares one key against every way of a set row.
module itd_match #(
   parameter int unsigned WAYS  = 4,
   parameter int unsigned TAG_W = 32,
   parameter int unsigned WAY_W = 2
) (
   input  logic [WAYS-1:0][TAG_W-1:0] row_tags,
   input  logic [WAYS-1:0]            row_vld,
   input  logic [TAG_W-1:0]           key,
   output logic [WAYS-1:0]            hits,
   output logic                       any,
   output logic [WAY_W-1:0]           way
);
   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign hits[w] = row_vld[w] && (row_tags[w] == key);
   end

   assign any = |hits;

   // Hits are one-hot, so OR-ing the way numbers encodes them.
   always_comb begin
      way = '0;
      for (int i = 0; i < WAYS; i++) begin
         if (hits[i]) way = way | WAY_W'(i);
      end
   end
endmodule

// File: rtl/itd_victim.sv
// Chooses the way a fill writes: lowest invalid way, else the pointer.
module itd_victim #(
   parameter int unsigned WAYS  = 4,
   parameter int unsigned WAY_W = 2
) (
   input  logic [WAYS-1:0]  row_vld,
   input  logic [WAY_W-1:0] ptr,
   output logic [WAY_W-1:0] way,
   output logic             full
);
   assign full = &row_vld;

   if (WAYS == 1) begin : g_single
      logic unused_ptr;
      assign unused_ptr = ^ptr;
      assign way = '0;
   end else begin : g_multi
      always_comb begin
         way = ptr;
         for (int i = WAYS - 1; i >= 0; i--) begin
            if (!row_vld[i]) way = WAY_W'(i);
         end
      end
   end
endmodule

// File: rtl/itd_store.sv
// Tag array, valid bits and per-set rotating pointers.
module itd_store #(
   parameter int unsigned SETS  = 16,
   parameter int unsigned WAYS  = 4,
   parameter int unsigned TAG_W = 32,
   parameter int unsigned SET_W = 4,
   parameter int unsigned WAY_W = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       flash,
   input  logic [SET_W-1:0]           lk_set,
   input  logic [SET_W-1:0]           fl_set,
   input  logic [SET_W-1:0]           iv_set,
   output logic [WAYS-1:0][TAG_W-1:0] lk_tags,
   output logic [WAYS-1:0]            lk_vld,
   output logic [WAYS-1:0][TAG_W-1:0] fl_tags,
   output logic [WAYS-1:0]            fl_vld,
   output logic [WAY_W-1:0]           fl_ptr,
   output logic [WAYS-1:0][TAG_W-1:0] iv_tags,
   output logic [WAYS-1:0]            iv_vld,
   input  logic                       wr_en,
   input  logic [WAY_W-1:0]           wr_way,
   input  logic [TAG_W-1:0]           wr_tag,
   input  logic                       adv_en,
   input  logic                       clr_en,
   input  logic [WAYS-1:0]            clr_mask,
   output logic [SETS*WAYS-1:0]       vld_flat
);
   localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);

   logic [WAYS-1:0][TAG_W-1:0] tag_q [SETS];
   logic [WAYS-1:0]            vld_q [SETS];
   logic [WAY_W-1:0]           ptr_q [SETS];

   for (genvar s = 0; s < SETS; s++) begin : g_set
      logic            wr_here, clr_here, adv_here;
      logic [WAYS-1:0] vld_nxt;

      assign wr_here  = wr_en  && (fl_set == SET_W'(s));
      assign adv_here = adv_en && (fl_set == SET_W'(s));
      assign clr_here = clr_en && (iv_set == SET_W'(s));

      always_comb begin
         vld_nxt = vld_q[s];
         if (clr_here) vld_nxt = vld_nxt & ~clr_mask;
         if (wr_here)  vld_nxt[wr_way] = 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q[s] <= '0;
         end else if (flash) begin
            vld_q[s] <= '0;
         end else begin
            vld_q[s] <= vld_nxt;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ptr_q[s] <= '0;
         end else if (adv_here) begin
            ptr_q[s] <= (ptr_q[s] == LAST_WAY) ? '0 : ptr_q[s] + 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (wr_here) tag_q[s][wr_way] <= wr_tag;
      end
   end

   assign lk_tags = tag_q[lk_set];
   assign lk_vld  = vld_q[lk_set];
   assign fl_tags = tag_q[fl_set];
   assign fl_vld  = vld_q[fl_set];
   assign fl_ptr  = ptr_q[fl_set];
   assign iv_tags = tag_q[iv_set];
   assign iv_vld  = vld_q[iv_set];

   always_comb begin
      for (int s = 0; s < SETS; s++) begin
         vld_flat[s*WAYS +: WAYS] = vld_q[s];
      end
   end
endmodule

// File: rtl/itd_directory.sv
// Directory of an instruction cache indexed by untranslated bits and
// tagged by {upper address, process ID, space bit}.
module itd_directory
   import itd_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned OFFSET_W = 5,
   parameter int unsigned INDEX_W  = 4,
   parameter int unsigned WAYS     = 64,
   localparam int unsigned WAY_W   = idx_w(WAYS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flash_inv,
   input  logic              lk_valid,
   input  logic [ADDR_W-1:0] lk_ea,
   input  logic [PID_W-1:0]  lk_pid,
   input  logic              lk_ispace,
   output logic              lk_resp_valid,
   output logic              lk_hit,
   output logic [WAY_W-1:0]  lk_way,
   input  logic              fill_valid,
   input  logic [ADDR_W-1:0] fill_ea,
   input  logic [PID_W-1:0]  fill_pid,
   input  logic              fill_ispace,
   input  logic              fill_exec,
   input  logic              fill_inhibit,
   input  logic              inv_valid,
   input  logic [ADDR_W-1:0] inv_ea,
   input  logic [PID_W-1:0]  inv_pid,
   input  logic              inv_dspace
);
   localparam int unsigned SETS  = 1 << INDEX_W;
   localparam int unsigned SET_W = INDEX_W;
   localparam int unsigned LOW_W = OFFSET_W + INDEX_W;
   localparam int unsigned HI_W  = ADDR_W - LOW_W;
   localparam int unsigned TAG_W = HI_W + PID_W + 1;

   // Elaboration-time parameter checks.
   if (INDEX_W < 1) begin : g_bad_index
      $error("itd_directory: INDEX_W must be at least 1");
   end
   if (WAYS < 1) begin : g_bad_ways
      $error("itd_directory: WAYS must be at least 1");
   end
   if (LOW_W > UNXLATE_W) begin : g_bad_split
      $error("itd_directory: index must lie in untranslated bits");
   end
   if (ADDR_W <= LOW_W) begin : g_bad_addr
      $error("itd_directory: address too narrow for offset and index");
   end

   // ---------------- address split ----------------
   logic [SET_W-1:0] lk_set, fl_set, iv_set;
   logic [TAG_W-1:0] lk_key, fl_key, iv_key;

   assign lk_set = lk_ea[LOW_W-1:OFFSET_W];
   assign fl_set = fill_ea[LOW_W-1:OFFSET_W];
   assign iv_set = inv_ea[LOW_W-1:OFFSET_W];

   assign lk_key = {lk_ea[ADDR_W-1:LOW_W],   lk_pid,   lk_ispace};
   assign fl_key = {fill_ea[ADDR_W-1:LOW_W], fill_pid, fill_ispace};
   assign iv_key = {inv_ea[ADDR_W-1:LOW_W],  inv_pid,  inv_dspace};

   logic unused_offsets;
   assign unused_offsets = ^{lk_ea[OFFSET_W-1:0], fill_ea[OFFSET_W-1:0],
                             inv_ea[OFFSET_W-1:0]};

   // ---------------- storage ----------------
   logic [WAYS-1:0][TAG_W-1:0] lk_tags, fl_tags, iv_tags;
   logic [WAYS-1:0]            lk_vld, fl_vld, iv_vld;
   logic [WAY_W-1:0]           fl_ptr;
   logic [SETS*WAYS-1:0]       vld_flat;

   logic             wr_en, adv_en, clr_en;
   logic [WAY_W-1:0] vic_way;
   logic             vic_full;

   // ---------------- compares ----------------
   logic [WAYS-1:0]  lk_hits, fl_hits, iv_hits;
   logic             lk_any, fl_any, iv_any;
   logic [WAY_W-1:0] lk_enc, fl_enc, iv_enc;

   itd_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_lk_match (
      .row_tags(lk_tags), .row_vld(lk_vld), .key(lk_key),
      .hits(lk_hits), .any(lk_any), .way(lk_enc));

   itd_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_fl_match (
      .row_tags(fl_tags), .row_vld(fl_vld), .key(fl_key),
      .hits(fl_hits), .any(fl_any), .way(fl_enc));

   itd_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_iv_match (
      .row_tags(iv_tags), .row_vld(iv_vld), .key(iv_key),
      .hits(iv_hits), .any(iv_any), .way(iv_enc));

   logic unused_enc;
   assign unused_enc = ^{fl_enc, iv_enc, fl_hits};

   itd_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
      .row_vld(fl_vld), .ptr(fl_ptr), .way(vic_way), .full(vic_full));

   // ---------------- request arbitration ----------------
   logic inv_same_lk, inv_same_fl, fill_allowed;

   assign inv_same_lk  = inv_valid && (iv_set == lk_set);
   assign inv_same_fl  = inv_valid && (iv_set == fl_set);
   assign fill_allowed = fill_exec && !fill_inhibit;

   assign clr_en = inv_valid && iv_any && !flash_inv;
   assign wr_en  = fill_valid && fill_allowed && !flash_inv
                   && !inv_same_fl && !fl_any;
   assign adv_en = wr_en && vic_full;

   itd_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .SET_W(SET_W),
               .WAY_W(WAY_W)) u_store (
      .clk(clk), .rst_n(rst_n), .flash(flash_inv),
      .lk_set(lk_set), .fl_set(fl_set), .iv_set(iv_set),
      .lk_tags(lk_tags), .lk_vld(lk_vld),
      .fl_tags(fl_tags), .fl_vld(fl_vld), .fl_ptr(fl_ptr),
      .iv_tags(iv_tags), .iv_vld(iv_vld),
      .wr_en(wr_en), .wr_way(vic_way), .wr_tag(fl_key),
      .adv_en(adv_en), .clr_en(clr_en), .clr_mask(iv_hits),
      .vld_flat(vld_flat));

   // ---------------- registered lookup response ----------------
   logic lk_hit_now;
   assign lk_hit_now = lk_valid && lk_any && !flash_inv && !inv_same_lk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lk_resp_valid <= 1'b0;
         lk_hit        <= 1'b0;
         lk_way        <= '0;
      end else begin
         lk_resp_valid <= lk_valid;
         lk_hit        <= lk_hit_now;
         lk_way        <= lk_hit_now ? lk_enc : '0;
      end
   end
endmodule

// Property checker attached to every directory instance.
module itd_directory_chk #(
   parameter int unsigned SETS  = 16,
   parameter int unsigned WAYS  = 4,
   parameter int unsigned SET_W = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 flash_inv,
   input logic                 lk_valid,
   input logic                 fill_valid,
   input logic                 fill_exec,
   input logic                 fill_inhibit,
   input logic                 inv_valid,
   input logic [SET_W-1:0]     lk_set,
   input logic [SET_W-1:0]     iv_set,
   input logic                 lk_resp_valid,
   input logic                 lk_hit,
   input logic [WAYS-1:0]      lk_hits,
   input logic [WAYS-1:0]      iv_hits,
   input logic [SETS*WAYS-1:0] vld_flat
);
   a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> lk_resp_valid);

   a_r2_resp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !lk_resp_valid && !lk_hit);

   a_r3_one_lookup_way: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_hits));

   a_r7_one_inv_way: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(iv_hits));

   a_r4_refused_fill: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid && (!fill_exec || fill_inhibit) && !inv_valid && !flash_inv
      |=> $stable(vld_flat));

   a_r8_flash_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flash_inv |=> (vld_flat == '0));

   a_r8_flash_miss: assert property (@(posedge clk) disable iff (!rst_n)
      flash_inv && lk_valid |=> !lk_hit);

   a_r9_inv_wins: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid && inv_valid && (lk_set == iv_set) |=> !lk_hit);
endmodule

bind itd_directory itd_directory_chk #(.SETS(SETS), .WAYS(WAYS),
                                       .SET_W(SET_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .flash_inv(flash_inv),
   .lk_valid(lk_valid), .fill_valid(fill_valid), .fill_exec(fill_exec),
   .fill_inhibit(fill_inhibit), .inv_valid(inv_valid),
   .lk_set(lk_set), .iv_set(iv_set),
   .lk_resp_valid(lk_resp_valid), .lk_hit(lk_hit),
   .lk_hits(lk_hits), .iv_hits(iv_hits), .vld_flat(vld_flat));

// File: tb/itd_directory_test.sv
module itd_directory_test;
   localparam int NW  = 4;
   localparam int NS  = 16;
   localparam int WW  = 2;
   localparam int TW  = 23 + 8 + 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flash_inv = 1'b0;
   logic        lk_valid = 1'b0, lk_ispace = 1'b0;
   logic [31:0] lk_ea = '0;
   logic [7:0]  lk_pid = '0;
   logic        lk_resp_valid, lk_hit;
   logic [WW-1:0] lk_way;
   logic        fill_valid = 1'b0, fill_ispace = 1'b0;
   logic        fill_exec = 1'b0, fill_inhibit = 1'b0;
   logic [31:0] fill_ea = '0;
   logic [7:0]  fill_pid = '0;
   logic        inv_valid = 1'b0, inv_dspace = 1'b0;
   logic [31:0] inv_ea = '0;
   logic [7:0]  inv_pid = '0;

   always #4 clk = ~clk;  // 125 MHz

   itd_directory #(.WAYS(NW)) uut (.*);

   // Bench model of the directory.
   logic [TW-1:0] m_tag [NS][NW];
   logic          m_vld [NS][NW];
   int            m_ptr [NS];

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   function automatic logic [31:0] mk_ea(input int hi, input int set,
                                         input int off);
      return {23'(hi), 4'(set), 5'(off)};
   endfunction

   function automatic logic [TW-1:0] mk_key(input logic [31:0] ea,
                                            input logic [7:0] pid,
                                            input logic sp);
      return {ea[31:9], pid, sp};
   endfunction

   function automatic int find(input int set, input logic [TW-1:0] key);
      for (int w = 0; w < NW; w++)
         if (m_vld[set][w] && m_tag[set][w] == key) return w;
      return -1;
   endfunction

   task automatic clear_inputs();
      lk_valid = 0; fill_valid = 0; inv_valid = 0; flash_inv = 0;
   endtask

   // Predict from the pre-edge model, update the model, clock, compare.
   task automatic run(input string req);
      bit exp_rv, exp_hit;
      int exp_way, li, fi, ii, w, v;
      exp_rv = lk_valid; exp_hit = 0; exp_way = 0;
      li = int'(lk_ea[8:5]); fi = int'(fill_ea[8:5]); ii = int'(inv_ea[8:5]);
      if (lk_valid && !flash_inv && !(inv_valid && ii == li)) begin
         w = find(li, mk_key(lk_ea, lk_pid, lk_ispace));
         if (w >= 0) begin exp_hit = 1; exp_way = w; end
      end
      if (flash_inv) begin
         for (int s = 0; s < NS; s++)
            for (int k = 0; k < NW; k++) m_vld[s][k] = 0;
      end else begin
         bit fill_ok;
         fill_ok = fill_valid && fill_exec && !fill_inhibit
                   && !(inv_valid && ii == fi)
                   && find(fi, mk_key(fill_ea, fill_pid, fill_ispace)) < 0;
         if (inv_valid) begin
            w = find(ii, mk_key(inv_ea, inv_pid, inv_dspace));
            if (w >= 0) m_vld[ii][w] = 0;
         end
         if (fill_ok) begin
            v = -1;
            for (int k = NW - 1; k >= 0; k--) if (!m_vld[fi][k]) v = k;
            if (v < 0) begin
               v = m_ptr[fi];
               m_ptr[fi] = (m_ptr[fi] + 1) % NW;
            end
            m_vld[fi][v] = 1;
            m_tag[fi][v] = mk_key(fill_ea, fill_pid, fill_ispace);
         end
      end
      @(posedge clk); #2;
      checks++;
      if (lk_resp_valid !== exp_rv || lk_hit !== exp_hit ||
          (exp_hit && int'(lk_way) != exp_way)) begin
         errors++;
         $display("FAIL %s: rv=%0b hit=%0b way=%0d expected rv=%0b hit=%0b way=%0d",
                  req, lk_resp_valid, lk_hit, lk_way, exp_rv, exp_hit, exp_way);
      end
      clear_inputs();
   endtask

   task automatic set_look(input logic [31:0] ea, input int pid, input bit sp);
      lk_valid = 1; lk_ea = ea; lk_pid = 8'(pid); lk_ispace = sp;
   endtask
   task automatic set_fill(input logic [31:0] ea, input int pid, input bit sp,
                           input bit ex, input bit inh);
      fill_valid = 1; fill_ea = ea; fill_pid = 8'(pid); fill_ispace = sp;
      fill_exec = ex; fill_inhibit = inh;
   endtask
   task automatic set_inv(input logic [31:0] ea, input int pid, input bit ds);
      inv_valid = 1; inv_ea = ea; inv_pid = 8'(pid); inv_dspace = ds;
   endtask

   task automatic look(input logic [31:0] ea, input int pid, input bit sp,
                       input string req);
      set_look(ea, pid, sp); run(req);
   endtask
   task automatic fill(input logic [31:0] ea, input int pid, input bit sp,
                       input string req);
      set_fill(ea, pid, sp, 1, 0); run(req);
   endtask

   // Direct check of a way value for R5, independent of the model's choice.
   task automatic expect_way(input logic [31:0] ea, input int pid, input bit sp,
                             input int way, input string req);
      set_look(ea, pid, sp); run(req);
      checks++;
      if (lk_hit !== 1'b1 || int'(lk_way) != way) begin
         errors++;
         $display("FAIL %s: hit=%0b way=%0d expected hit=1 way=%0d",
                  req, lk_hit, lk_way, way);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R2 watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int s = 0; s < NS; s++) begin
         m_ptr[s] = 0;
         for (int k = 0; k < NW; k++) begin m_vld[s][k] = 0; m_tag[s][k] = '0; end
      end
      repeat (3) @(posedge clk); #2;
      checks++;
      if (lk_resp_valid !== 0 || lk_hit !== 0 || lk_way !== '0) begin
         errors++;
         $display("FAIL R12: rv=%0b hit=%0b way=%0d expected 0 0 0",
                  lk_resp_valid, lk_hit, lk_way);
      end
      rst_n = 1;

      // R12: empty after reset; R2: idle cycle gives no response.
      look(mk_ea(5, 3, 0), 1, 0, "R12");
      run("R2");

      // R11: same-cycle fill is not seen; R1/R5: next lookup hits way 0.
      set_fill(mk_ea(5, 3, 0), 1, 0, 1, 0);
      set_look(mk_ea(5, 3, 0), 1, 0);
      run("R11");
      expect_way(mk_ea(5, 3, 7), 1, 0, 0, "R1");
      look(mk_ea(5, 3, 0), 2, 0, "R1");
      look(mk_ea(5, 3, 0), 1, 1, "R1");
      look(mk_ea(6, 3, 0), 1, 0, "R1");
      look(mk_ea(5, 4, 0), 1, 0, "R1");

      // R4: refused fills.
      set_fill(mk_ea(9, 2, 0), 1, 0, 0, 0); run("R4");
      set_fill(mk_ea(9, 2, 0), 1, 0, 1, 1); run("R4");
      look(mk_ea(9, 2, 0), 1, 0, "R4");

      // R5: fill set 3 up, then rotate.
      fill(mk_ea(10, 3, 0), 1, 0, "R5");
      fill(mk_ea(11, 3, 0), 1, 0, "R5");
      fill(mk_ea(12, 3, 0), 1, 0, "R5");
      expect_way(mk_ea(12, 3, 0), 1, 0, 3, "R5");
      fill(mk_ea(13, 3, 0), 1, 0, "R5");
      expect_way(mk_ea(13, 3, 0), 1, 0, 0, "R5");
      look(mk_ea(5, 3, 0), 1, 0, "R5");
      // R6: duplicate fill leaves pointer and ways alone.
      fill(mk_ea(11, 3, 0), 1, 0, "R6");
      expect_way(mk_ea(11, 3, 0), 1, 0, 2, "R6");
      fill(mk_ea(14, 3, 0), 1, 0, "R6");
      expect_way(mk_ea(14, 3, 0), 1, 0, 1, "R6");
      expect_way(mk_ea(11, 3, 0), 1, 0, 2, "R6");
      // R5: freed way reused before the pointer.
      set_inv(mk_ea(12, 3, 0), 1, 0); run("R7");
      fill(mk_ea(15, 3, 0), 1, 0, "R5");
      expect_way(mk_ea(15, 3, 0), 1, 0, 3, "R5");

      // R7: synonyms in set 7.
      fill(mk_ea(20, 7, 0), 4, 0, "R7");
      fill(mk_ea(21, 7, 0), 4, 0, "R7");
      fill(mk_ea(20, 7, 0), 5, 0, "R7");
      fill(mk_ea(20, 7, 0), 4, 1, "R7");
      set_inv(mk_ea(20, 7, 0), 4, 1); run("R7");
      look(mk_ea(20, 7, 0), 4, 1, "R7");
      expect_way(mk_ea(20, 7, 0), 4, 0, 0, "R7");
      expect_way(mk_ea(21, 7, 0), 4, 0, 1, "R7");
      expect_way(mk_ea(20, 7, 0), 5, 0, 2, "R7");
      set_inv(mk_ea(22, 7, 0), 4, 0); run("R7");
      expect_way(mk_ea(20, 7, 0), 4, 0, 0, "R7");

      // R9: same-set invalidate (of another line) forces a miss.
      set_look(mk_ea(21, 7, 0), 4, 0); set_inv(mk_ea(20, 7, 0), 5, 0);
      run("R9");
      expect_way(mk_ea(21, 7, 0), 4, 0, 1, "R9");
      set_look(mk_ea(21, 7, 0), 4, 0); set_inv(mk_ea(5, 3, 0), 9, 0);
      run("R9");

      // R10: fill and invalidate in one set.
      set_fill(mk_ea(30, 8, 0), 1, 0, 1, 0); set_inv(mk_ea(31, 8, 0), 1, 0);
      run("R10");
      look(mk_ea(30, 8, 0), 1, 0, "R10");

      // R8: flash with a lookup and a fill.
      set_look(mk_ea(21, 7, 0), 4, 0); set_fill(mk_ea(40, 9, 0), 1, 0, 1, 0);
      flash_inv = 1; run("R8");
      look(mk_ea(21, 7, 0), 4, 0, "R8");
      look(mk_ea(40, 9, 0), 1, 0, "R8");
      look(mk_ea(14, 3, 0), 1, 0, "R8");

      // R1/R3: constrained random mix against the model.
      for (int n = 0; n < 4000; n++) begin
         if ($urandom_range(99) < 60)
            set_look(mk_ea($urandom_range(3), $urandom_range(3), $urandom_range(31)),
                     $urandom_range(2), 1'($urandom_range(1)));
         if ($urandom_range(99) < 40)
            set_fill(mk_ea($urandom_range(3), $urandom_range(3), 0),
                     $urandom_range(2), 1'($urandom_range(1)),
                     $urandom_range(9) != 0, $urandom_range(9) == 0);
         if ($urandom_range(99) < 20)
            set_inv(mk_ea($urandom_range(3), $urandom_range(3), 0),
                    $urandom_range(2), 1'($urandom_range(1)));
         if ($urandom_range(499) == 0) flash_inv = 1;
         run("R3");
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule